// File: doc/BRIEF.md
# Age-Ordered Node Scheduling Table

This block is the waiting room between issue and execution in a dynamically scheduled core. Each cycle it can take one issue word of up to four nodes: three arithmetic nodes and one memory node. Every node carries a destination tag and two source operands. An operand arrives either as a ready value or as a tag it must still wait for. Nodes leave the table independently of their word-mates as soon as both operands are ready. Every cycle the table can send up to three arithmetic nodes and one memory node to the function units, which are taken to be fully pipelined.

Storage is organised as banks, and one bank holds one execution atomic unit. Banks are allocated in a circular order, and that order defines age. Within a bank, a lower slot index is older. A single result broadcast wakes waiting operands, including operands of a word that is being written in the same cycle. A flush names a bank and discards it together with every younger bank, which is used when a branch assertion fails. A per-bank completion flag lets the retirement logic free the oldest bank once all of its nodes have left.

Top module: `node_sched`

## Requirements
- R1: After reset the table is empty. `inReady` is 1, `allocBank` is 0, `bankDone` is all zeros, and no ALU or memory dispatch is valid.
- R2: When `inValid` and `inReady` are both high at a rising edge, the word is written into bank `allocBank`. Slot s uses bits [s*TAG_W +: TAG_W] and [s*DATA_W +: DATA_W] of the flat inputs. Slots 0 to 2 are ALU nodes and slot 3 is the memory node. A slot whose `inNodeVld` bit is 0 stores nothing. `allocBank` then advances by one, modulo the bank count.
- R3: A stored node is dispatched only when both of its operands are ready. It appears on a dispatch port in the cycle after the edge that made it ready, and it is dispatched exactly once.
- R4: Each cycle at most three ALU nodes and one memory node are dispatched. ALU port k uses bits [k*TAG_W +: TAG_W] and [k*DATA_W +: DATA_W], and ports are filled from port 0 upward.
- R5: Among ready nodes, an older bank in allocation order wins over a younger bank, including after the bank index has wrapped. Within a bank, a lower slot wins over a higher slot.
- R6: A result broadcast (`resValid`, `resTag`, `resData`) writes `resData` into every stored waiting operand whose tag matches. That operand is ready from the next cycle on.
- R7: A broadcast in the same cycle as an issue is captured by the matching pending operands of the incoming word.
- R8: A flush naming an occupied bank discards that bank and all younger banks, and none of their nodes is ever dispatched. Older banks are kept, and `allocBank` becomes the flushed bank. A flush naming an unoccupied bank changes nothing. `inReady` is low in any cycle with `flushValid` high.
- R9: When all banks are occupied, `inReady` is low and an offered word is ignored.
- R10: `bankDone[b]` is high while bank b is occupied and none of its nodes remains undispatched.
- R11: `retireValid` frees the oldest bank only if that bank's `bankDone` flag is set. Otherwise the retire request is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Issue word offered |
| inReady | output | 1 | Issue word can be accepted this cycle |
| allocBank | output | BANK_W | Bank the next accepted word is written into |
| inNodeVld | input | 4 | Per-slot node present |
| inDst | input | 4*TAG_W | Per-slot destination tag |
| inARdy | input | 4 | Per-slot first operand is a value |
| inATag | input | 4*TAG_W | Per-slot first operand tag when pending |
| inAVal | input | 4*DATA_W | Per-slot first operand value when ready |
| inBRdy | input | 4 | Per-slot second operand is a value |
| inBTag | input | 4*TAG_W | Per-slot second operand tag when pending |
| inBVal | input | 4*DATA_W | Per-slot second operand value when ready |
| resValid | input | 1 | Result broadcast valid |
| resTag | input | TAG_W | Broadcast result tag |
| resData | input | DATA_W | Broadcast result value |
| flushValid | input | 1 | Discard a bank and all younger banks |
| flushBank | input | BANK_W | Oldest bank to discard |
| retireValid | input | 1 | Request to free the oldest bank |
| aluVld | output | 3 | Per-port ALU dispatch valid |
| aluDst | output | 3*TAG_W | Per-port ALU destination tag |
| aluA | output | 3*DATA_W | Per-port ALU first operand |
| aluB | output | 3*DATA_W | Per-port ALU second operand |
| memVld | output | 1 | Memory dispatch valid |
| memDst | output | TAG_W | Memory destination tag |
| memA | output | DATA_W | Memory first operand |
| memB | output | DATA_W | Memory second operand |
| bankDone | output | NUM_BANKS | Per-bank all-dispatched flag |

## Verification
Dispatch outputs are combinational from stored state. A node is therefore visible on a port between the rising edge that stored it already ready, or that delivered its last operand, and the following rising edge, which removes it. `bankDone` rises right after the edge that removes a bank's last node. A retire or flush takes effect at the next edge, while `inReady` drops combinationally in the same cycle that a flush is driven. The bench drives every input on the falling edge and samples one falling edge later, so each check sees exactly one rising edge of effect. The flush-time `inReady` check is the exception: it is sampled just after the flush input is driven.

// File: rtl/sched_pkg.sv
`timescale 1ns/1ps
package sched_pkg;
  localparam int unsigned NUM_BANKS  = 4;
  localparam int unsigned ALU_SLOTS  = 3;
  localparam int unsigned WORD_SLOTS = ALU_SLOTS + 1;
  localparam int unsigned MEM_SLOT   = ALU_SLOTS;
  localparam int unsigned BANK_W     = $clog2(NUM_BANKS);

  // Strobes from the bank controller to the entry datapath
  typedef struct packed {
    logic                 allocEn;
    logic [BANK_W-1:0]    allocBank;
    logic [NUM_BANKS-1:0] killMask;
    logic [BANK_W-1:0]    headBank;
  } ctrl_strobe_t;
endpackage

// File: rtl/sched_age_picker.sv
`timescale 1ns/1ps
// Picks up to K requests, lowest index first (index 0 is the oldest).
module sched_age_picker #(
  parameter int unsigned N = 4,
  parameter int unsigned K = 1,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]         req,
  output logic [K-1:0]         gntVld,
  output logic [K-1:0][IW-1:0] gntIdx
);
  logic [N-1:0] remain;

  always_comb begin
    remain = req;
    gntVld = '0;
    gntIdx = '0;
    for (int k = 0; k < K; k++) begin
      for (int i = 0; i < N; i++) begin
        if (!gntVld[k] && remain[i]) begin
          gntVld[k] = 1'b1;
          gntIdx[k] = IW'(i);
        end
      end
      if (gntVld[k]) remain[gntIdx[k]] = 1'b0;
    end
  end
endmodule

// File: rtl/sched_ctrl.sv
`timescale 1ns/1ps
module sched_ctrl
  import sched_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 inValid,
  input  logic                 flushValid,
  input  logic [BANK_W-1:0]    flushBank,
  input  logic                 retireValid,
  input  logic [NUM_BANKS-1:0] bankPend,
  output logic                 inReady,
  output logic [BANK_W-1:0]    allocBank,
  output logic [NUM_BANKS-1:0] bankDone,
  output ctrl_strobe_t         strobe
);
  localparam int unsigned CNT_W = BANK_W + 1;

  logic [BANK_W-1:0]    headQ, tailQ;
  logic [CNT_W-1:0]     countQ;
  logic [NUM_BANKS-1:0] occQ, occNext, killMask;
  logic                 flushHit, allocEn, retireEn;
  logic [BANK_W-1:0]    flushAge, bankAge;

  always_comb begin
    flushHit = flushValid && occQ[flushBank];
    flushAge = flushBank - headQ;
    killMask = '0;
    bankAge  = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      bankAge = BANK_W'(b) - headQ;
      if (flushHit && occQ[b] && (bankAge >= flushAge)) killMask[b] = 1'b1;
    end
  end

  assign inReady  = (countQ < CNT_W'(NUM_BANKS)) && !flushValid;
  assign allocEn  = inValid && inReady;
  assign retireEn = retireValid && !flushValid && occQ[headQ] && !bankPend[headQ];
  assign bankDone = occQ & ~bankPend;
  assign allocBank = tailQ;

  always_comb begin
    occNext = occQ;
    if (allocEn)  occNext[tailQ] = 1'b1;
    if (retireEn) occNext[headQ] = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      headQ  <= '0;
      tailQ  <= '0;
      countQ <= '0;
      occQ   <= '0;
    end else if (flushHit) begin
      occQ   <= occQ & ~killMask;
      tailQ  <= flushBank;
      countQ <= CNT_W'(flushAge);
    end else begin
      occQ   <= occNext;
      if (allocEn)  tailQ <= tailQ + BANK_W'(1);
      if (retireEn) headQ <= headQ + BANK_W'(1);
      countQ <= countQ + CNT_W'(allocEn) - CNT_W'(retireEn);
    end
  end

  assign strobe.allocEn   = allocEn;
  assign strobe.allocBank = tailQ;
  assign strobe.killMask  = killMask;
  assign strobe.headBank  = headQ;

  // R9: occupancy count and occupied-bank flags stay consistent
  a_r9_count_matches: assert property (@(posedge clk) disable iff (!rstN)
    $countones(occQ) == int'(countQ));
  // R2: a word is only written into a free bank
  a_r2_alloc_into_free: assert property (@(posedge clk) disable iff (!rstN)
    allocEn |-> !occQ[tailQ]);
  // R11: a retired bank is no longer occupied afterwards
  a_r11_retire_frees: assert property (@(posedge clk) disable iff (!rstN)
    retireEn |=> !occQ[$past(headQ)]);
  // R8: after a flush the next word goes into the flushed bank
  a_r8_flush_rewinds: assert property (@(posedge clk) disable iff (!rstN)
    flushHit |=> (allocBank == $past(flushBank)));
endmodule

// File: rtl/sched_datapath.sv
`timescale 1ns/1ps
module sched_datapath
  import sched_pkg::*;
#(
  parameter int unsigned TAG_W  = 6,
  parameter int unsigned DATA_W = 16
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  ctrl_strobe_t                   strobe,
  input  logic [WORD_SLOTS-1:0]          inNodeVld,
  input  logic [WORD_SLOTS*TAG_W-1:0]    inDst,
  input  logic [WORD_SLOTS-1:0]          inARdy,
  input  logic [WORD_SLOTS*TAG_W-1:0]    inATag,
  input  logic [WORD_SLOTS*DATA_W-1:0]   inAVal,
  input  logic [WORD_SLOTS-1:0]          inBRdy,
  input  logic [WORD_SLOTS*TAG_W-1:0]    inBTag,
  input  logic [WORD_SLOTS*DATA_W-1:0]   inBVal,
  input  logic                           resValid,
  input  logic [TAG_W-1:0]               resTag,
  input  logic [DATA_W-1:0]              resData,
  output logic [NUM_BANKS-1:0]           bankPend,
  output logic [ALU_SLOTS-1:0]           aluVld,
  output logic [ALU_SLOTS*TAG_W-1:0]     aluDst,
  output logic [ALU_SLOTS*DATA_W-1:0]    aluA,
  output logic [ALU_SLOTS*DATA_W-1:0]    aluB,
  output logic                           memVld,
  output logic [TAG_W-1:0]               memDst,
  output logic [DATA_W-1:0]              memA,
  output logic [DATA_W-1:0]              memB
);
  localparam int unsigned NE  = NUM_BANKS * WORD_SLOTS;
  localparam int unsigned NA  = NUM_BANKS * ALU_SLOTS;
  localparam int unsigned AIW = (NA > 1) ? $clog2(NA) : 1;
  localparam int unsigned MIW = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

  logic              eVld  [NE];
  logic [TAG_W-1:0]  eDst  [NE];
  logic              eARdy [NE];
  logic [TAG_W-1:0]  eATag [NE];
  logic [DATA_W-1:0] eAVal [NE];
  logic              eBRdy [NE];
  logic [TAG_W-1:0]  eBTag [NE];
  logic [DATA_W-1:0] eBVal [NE];

  logic [NE-1:0] entryRdy, dispClr;
  logic [NA-1:0] aluReq;
  logic [NUM_BANKS-1:0] memReq;
  logic [ALU_SLOTS-1:0] aluPickVld;
  logic [ALU_SLOTS-1:0][AIW-1:0] aluPickIdx;
  logic [0:0] memPickVld;
  logic [0:0][MIW-1:0] memPickIdx;

  always_comb begin
    for (int e = 0; e < NE; e++) entryRdy[e] = eVld[e] && eARdy[e] && eBRdy[e];
    for (int b = 0; b < NUM_BANKS; b++) begin
      bankPend[b] = 1'b0;
      for (int s = 0; s < WORD_SLOTS; s++) bankPend[b] = bankPend[b] | eVld[b*WORD_SLOTS+s];
    end
  end

  // Present requests in age order: position 0 is the head bank
  always_comb begin
    logic [BANK_W-1:0] bnk;
    for (int a = 0; a < NUM_BANKS; a++) begin
      bnk = strobe.headBank + BANK_W'(a);
      for (int s = 0; s < ALU_SLOTS; s++)
        aluReq[a*ALU_SLOTS+s] = entryRdy[int'(bnk)*WORD_SLOTS+s];
      memReq[a] = entryRdy[int'(bnk)*WORD_SLOTS+MEM_SLOT];
    end
  end

  sched_age_picker #(.N(NA), .K(ALU_SLOTS)) aluPick_i (
    .req(aluReq), .gntVld(aluPickVld), .gntIdx(aluPickIdx)
  );
  sched_age_picker #(.N(NUM_BANKS), .K(1)) memPick_i (
    .req(memReq), .gntVld(memPickVld), .gntIdx(memPickIdx)
  );

  // Map grants back to entries and drive the dispatch ports
  always_comb begin
    logic [BANK_W-1:0] bnk;
    int e;
    dispClr = '0;
    aluVld = '0; aluDst = '0; aluA = '0; aluB = '0;
    memVld = 1'b0; memDst = '0; memA = '0; memB = '0;
    bnk = '0;
    e = 0;
    for (int k = 0; k < ALU_SLOTS; k++) begin
      if (aluPickVld[k]) begin
        bnk = strobe.headBank + BANK_W'(int'(aluPickIdx[k]) / ALU_SLOTS);
        e = int'(bnk) * WORD_SLOTS + (int'(aluPickIdx[k]) % ALU_SLOTS);
        dispClr[e] = 1'b1;
        aluVld[k] = 1'b1;
        aluDst[k*TAG_W +: TAG_W]   = eDst[e];
        aluA[k*DATA_W +: DATA_W]   = eAVal[e];
        aluB[k*DATA_W +: DATA_W]   = eBVal[e];
      end
    end
    if (memPickVld[0]) begin
      bnk = strobe.headBank + BANK_W'(memPickIdx[0]);
      e = int'(bnk) * WORD_SLOTS + MEM_SLOT;
      dispClr[e] = 1'b1;
      memVld = 1'b1;
      memDst = eDst[e];
      memA   = eAVal[e];
      memB   = eBVal[e];
    end
  end

  // Entry storage: kill, allocate, or dispatch/wake-up
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int e = 0; e < NE; e++) begin
        eVld[e] <= 1'b0; eDst[e] <= '0;
        eARdy[e] <= 1'b0; eATag[e] <= '0; eAVal[e] <= '0;
        eBRdy[e] <= 1'b0; eBTag[e] <= '0; eBVal[e] <= '0;
      end
    end else begin
      for (int e = 0; e < NE; e++) begin
        if (strobe.killMask[e / WORD_SLOTS]) begin
          eVld[e] <= 1'b0;
        end else if (strobe.allocEn && (int'(strobe.allocBank) == e / WORD_SLOTS)) begin
          eVld[e]  <= inNodeVld[e % WORD_SLOTS];
          eDst[e]  <= inDst[(e % WORD_SLOTS)*TAG_W +: TAG_W];
          eATag[e] <= inATag[(e % WORD_SLOTS)*TAG_W +: TAG_W];
          eBTag[e] <= inBTag[(e % WORD_SLOTS)*TAG_W +: TAG_W];
          if (inARdy[e % WORD_SLOTS]) begin
            eARdy[e] <= 1'b1;
            eAVal[e] <= inAVal[(e % WORD_SLOTS)*DATA_W +: DATA_W];
          end else begin
            eARdy[e] <= resValid && (inATag[(e % WORD_SLOTS)*TAG_W +: TAG_W] == resTag);
            eAVal[e] <= resData;
          end
          if (inBRdy[e % WORD_SLOTS]) begin
            eBRdy[e] <= 1'b1;
            eBVal[e] <= inBVal[(e % WORD_SLOTS)*DATA_W +: DATA_W];
          end else begin
            eBRdy[e] <= resValid && (inBTag[(e % WORD_SLOTS)*TAG_W +: TAG_W] == resTag);
            eBVal[e] <= resData;
          end
        end else begin
          if (dispClr[e]) eVld[e] <= 1'b0;
          if (resValid && !eARdy[e] && (eATag[e] == resTag)) begin
            eARdy[e] <= 1'b1;
            eAVal[e] <= resData;
          end
          if (resValid && !eBRdy[e] && (eBTag[e] == resTag)) begin
            eBRdy[e] <= 1'b1;
            eBVal[e] <= resData;
          end
        end
      end
    end
  end

  // R4: ALU ports fill from port 0 upward
  for (genvar k = 0; k + 1 < ALU_SLOTS; k++) begin : g_pack
    a_r4_ports_packed: assert property (@(posedge clk) disable iff (!rstN)
      !aluVld[k] |-> !aluVld[k+1]);
  end

  // R8: a discarded bank holds no pending node afterwards
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_kill
    a_r8_killed_bank_empty: assert property (@(posedge clk) disable iff (!rstN)
      strobe.killMask[b] |=> !bankPend[b]);
  end
endmodule

// File: rtl/node_sched.sv
`timescale 1ns/1ps
module node_sched
  import sched_pkg::*;
#(
  parameter int unsigned TAG_W  = 6,
  parameter int unsigned DATA_W = 16
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           inValid,
  output logic                           inReady,
  output logic [BANK_W-1:0]              allocBank,
  input  logic [WORD_SLOTS-1:0]          inNodeVld,
  input  logic [WORD_SLOTS*TAG_W-1:0]    inDst,
  input  logic [WORD_SLOTS-1:0]          inARdy,
  input  logic [WORD_SLOTS*TAG_W-1:0]    inATag,
  input  logic [WORD_SLOTS*DATA_W-1:0]   inAVal,
  input  logic [WORD_SLOTS-1:0]          inBRdy,
  input  logic [WORD_SLOTS*TAG_W-1:0]    inBTag,
  input  logic [WORD_SLOTS*DATA_W-1:0]   inBVal,
  input  logic                           resValid,
  input  logic [TAG_W-1:0]               resTag,
  input  logic [DATA_W-1:0]              resData,
  input  logic                           flushValid,
  input  logic [BANK_W-1:0]              flushBank,
  input  logic                           retireValid,
  output logic [ALU_SLOTS-1:0]           aluVld,
  output logic [ALU_SLOTS*TAG_W-1:0]     aluDst,
  output logic [ALU_SLOTS*DATA_W-1:0]    aluA,
  output logic [ALU_SLOTS*DATA_W-1:0]    aluB,
  output logic                           memVld,
  output logic [TAG_W-1:0]               memDst,
  output logic [DATA_W-1:0]              memA,
  output logic [DATA_W-1:0]              memB,
  output logic [NUM_BANKS-1:0]           bankDone
);
  ctrl_strobe_t         strobe;
  logic [NUM_BANKS-1:0] bankPend;

  sched_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .flushValid(flushValid),
    .flushBank(flushBank), .retireValid(retireValid), .bankPend(bankPend),
    .inReady(inReady), .allocBank(allocBank), .bankDone(bankDone), .strobe(strobe)
  );

  sched_datapath #(.TAG_W(TAG_W), .DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .inNodeVld(inNodeVld), .inDst(inDst),
    .inARdy(inARdy), .inATag(inATag), .inAVal(inAVal),
    .inBRdy(inBRdy), .inBTag(inBTag), .inBVal(inBVal),
    .resValid(resValid), .resTag(resTag), .resData(resData),
    .bankPend(bankPend),
    .aluVld(aluVld), .aluDst(aluDst), .aluA(aluA), .aluB(aluB),
    .memVld(memVld), .memDst(memDst), .memA(memA), .memB(memB)
  );
endmodule

// File: tb/node_sched_tb_top.sv
`timescale 1ns/1ps
module node_sched_tb_top;
  localparam int TW = 6;
  localparam int DW = 16;
  localparam int NS = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid, inReady, resValid, flushValid, retireValid;
  logic [1:0] allocBank, flushBank;
  logic [NS-1:0] inNodeVld, inARdy, inBRdy;
  logic [NS*TW-1:0] inDst, inATag, inBTag;
  logic [NS*DW-1:0] inAVal, inBVal;
  logic [TW-1:0] resTag;
  logic [DW-1:0] resData;
  logic [2:0] aluVld;
  logic [3*TW-1:0] aluDst;
  logic [3*DW-1:0] aluA, aluB;
  logic memVld;
  logic [TW-1:0] memDst;
  logic [DW-1:0] memA, memB;
  logic [3:0] bankDone;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  node_sched #(.TAG_W(TW), .DATA_W(DW)) dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .allocBank(allocBank),
    .inNodeVld(inNodeVld), .inDst(inDst), .inARdy(inARdy), .inATag(inATag), .inAVal(inAVal),
    .inBRdy(inBRdy), .inBTag(inBTag), .inBVal(inBVal),
    .resValid(resValid), .resTag(resTag), .resData(resData),
    .flushValid(flushValid), .flushBank(flushBank), .retireValid(retireValid),
    .aluVld(aluVld), .aluDst(aluDst), .aluA(aluA), .aluB(aluB),
    .memVld(memVld), .memDst(memDst), .memA(memA), .memB(memB), .bankDone(bankDone)
  );

  typedef struct packed {
    logic [3:0] vld;
    logic [3:0] aRdy;
    logic [3:0] bRdy;
    logic [2:0] expAlu;
    logic       expMem;
    logic [5:0] expDst0;
  } vec_t;

  // Single word into an empty table; slot s has dst 8+s, pending tags 63
  localparam vec_t VECS [6] = '{
    '{4'b1111, 4'b1111, 4'b1111, 3'b111, 1'b1, 6'd8},
    '{4'b1111, 4'b0000, 4'b1111, 3'b000, 1'b0, 6'd0},
    '{4'b1111, 4'b1111, 4'b0101, 3'b011, 1'b0, 6'd8},
    '{4'b0110, 4'b1111, 4'b1111, 3'b011, 1'b0, 6'd9},
    '{4'b1000, 4'b1111, 4'b1111, 3'b000, 1'b1, 6'd0},
    '{4'b1011, 4'b1110, 4'b1111, 3'b001, 1'b1, 6'd9}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic clearInputs();
    inValid = 0; inNodeVld = '0; inDst = '0; inARdy = '0; inBRdy = '0;
    inATag = '0; inBTag = '0;
    for (int s = 0; s < NS; s++) begin
      inAVal[s*DW +: DW] = DW'(16'h100 + s);
      inBVal[s*DW +: DW] = DW'(16'h200 + s);
    end
    resValid = 0; resTag = '0; resData = '0;
    flushValid = 0; flushBank = '0; retireValid = 0;
  endtask

  task automatic setNode(input int s, input logic [5:0] dst, input logic aR,
                         input logic [5:0] aTag, input logic bR);
    inNodeVld[s] = 1'b1;
    inDst[s*TW +: TW] = dst;
    inARdy[s] = aR;
    inATag[s*TW +: TW] = aTag;
    inBRdy[s] = bR;
    inBTag[s*TW +: TW] = 6'd63;
  endtask

  task automatic doReset();
    clearInputs();
    rstN = 0;
    repeat (2) step();
    rstN = 1;
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual running expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    doReset();
    // R1 reset state
    check("R1 inReady", 64'(inReady), 64'd1);
    check("R1 allocBank", 64'(allocBank), 64'd0);
    check("R1 bankDone", 64'(bankDone), 64'd0);
    check("R1 no dispatch", 64'({aluVld, memVld}), 64'd0);

    // R2 R3 R4 table walk: issue, observe, flush the bank
    foreach (VECS[i]) begin
      clearInputs();
      for (int s = 0; s < NS; s++) begin
        if (VECS[i].vld[s]) setNode(s, 6'(8 + s), VECS[i].aRdy[s], 6'd63, VECS[i].bRdy[s]);
      end
      inValid = 1;
      step();
      clearInputs();
      check("R3 alu dispatch mask", 64'(aluVld), 64'(VECS[i].expAlu));
      check("R2 mem dispatch", 64'(memVld), 64'(VECS[i].expMem));
      if (VECS[i].expAlu[0]) check("R4 port0 dst", 64'(aluDst[5:0]), 64'(VECS[i].expDst0));
      flushValid = 1; flushBank = allocBank - 2'd1;
      step();
      clearInputs();
    end

    // R5 R6 age ordering across two banks, memory too
    doReset();
    for (int s = 0; s < NS; s++) setNode(s, 6'(16 + s), 1'b0, 6'd5, 1'b1);
    inValid = 1; step();
    for (int s = 0; s < NS; s++) setNode(s, 6'(32 + s), 1'b0, 6'd5, 1'b1);
    step();
    clearInputs();
    check("R3 pending not dispatched", 64'({aluVld, memVld}), 64'd0);
    resValid = 1; resTag = 6'd5; resData = 16'hBEEF;
    step();
    clearInputs();
    check("R5 older bank alu", 64'(aluDst), 64'({6'd18, 6'd17, 6'd16}));
    check("R5 older bank mem", 64'(memDst), 64'd19);
    check("R6 woken value", 64'(aluA[15:0]), 64'hBEEF);
    step();
    check("R5 younger bank alu", 64'(aluDst), 64'({6'd34, 6'd33, 6'd32}));
    check("R5 younger bank mem", 64'(memDst), 64'd35);
    check("R10 done after first bank", 64'(bankDone), 64'b0001);
    step();
    check("R10 both done", 64'(bankDone), 64'b0011);
    retireValid = 1; step();
    check("R11 retire bank0", 64'(bankDone), 64'b0010);
    step(); retireValid = 0;
    check("R11 retire bank1", 64'(bankDone), 64'b0000);
    setNode(0, 6'd40, 1'b0, 6'd6, 1'b1);
    inValid = 1; step(); clearInputs();
    retireValid = 1; step(); retireValid = 0;
    resValid = 1; resTag = 6'd6; step(); clearInputs();
    step();
    check("R11 retire of undone bank ignored", 64'(bankDone), 64'b0100);

    // R7 broadcast captured at issue
    doReset();
    setNode(0, 6'd1, 1'b0, 6'd9, 1'b1);
    setNode(1, 6'd2, 1'b0, 6'd10, 1'b1);
    inValid = 1; resValid = 1; resTag = 6'd9; resData = 16'h1234;
    step(); clearInputs();
    check("R7 captured node dispatched", 64'(aluVld), 64'b001);
    check("R7 captured value", 64'(aluA[15:0]), 64'h1234);
    check("R7 ready operand kept", 64'(aluB[15:0]), 64'h0200);

    // R8 flush middle bank
    doReset();
    for (int b = 0; b < 3; b++) begin
      clearInputs();
      setNode(0, 6'(48 + b), 1'b0, 6'd7, 1'b1);
      inValid = 1; step();
    end
    clearInputs();
    flushValid = 1; flushBank = 2'd1;
    #1;
    check("R8 no issue during flush", 64'(inReady), 64'd0);
    step(); clearInputs();
    check("R8 alloc rewinds", 64'(allocBank), 64'd1);
    resValid = 1; resTag = 6'd7; step(); clearInputs();
    check("R8 only older dispatched", 64'(aluVld), 64'b001);
    check("R8 older dst", 64'(aluDst[5:0]), 64'd48);
    step();
    check("R8 flushed never dispatched", 64'(aluVld), 64'd0);
    check("R8 older bank kept", 64'(bankDone), 64'b0001);
    flushValid = 1; flushBank = 2'd3; step(); clearInputs();
    check("R8 flush of free bank ignored", 64'(allocBank), 64'd1);

    // R9 stall when full
    doReset();
    for (int b = 0; b < 4; b++) begin
      clearInputs();
      setNode(0, 6'(56 + b), 1'b0, 6'd20, 1'b1);
      inValid = 1; step();
    end
    clearInputs();
    check("R9 full not ready", 64'(inReady), 64'd0);
    setNode(0, 6'd63, 1'b1, 6'd0, 1'b1);
    inValid = 1; step(); clearInputs();
    check("R9 offered word ignored", 64'(aluVld), 64'd0);
    resValid = 1; resTag = 6'd20; step(); clearInputs();
    check("R4 three oldest", 64'(aluDst), 64'({6'd58, 6'd57, 6'd56}));
    step();
    check("R4 fourth next cycle", 64'({aluVld, aluDst[5:0]}), 64'({3'b001, 6'd59}));
    step();
    check("R9 ignored word absent", 64'(aluVld), 64'd0);

    // R5 age after bank index wrap
    doReset();
    for (int w = 0; w < 3; w++) begin
      clearInputs();
      setNode(0, 6'(w), 1'b1, 6'd0, 1'b1);
      inValid = 1; step();
    end
    clearInputs(); step();
    check("R10 three done", 64'(bankDone), 64'b0111);
    retireValid = 1; repeat (3) step(); retireValid = 0;
    check("R5 alloc at bank3", 64'(allocBank), 64'd3);
    for (int s = 0; s < 3; s++) setNode(s, 6'(4 + s), 1'b0, 6'd40, 1'b1);
    inValid = 1; step(); clearInputs();
    for (int s = 0; s < 3; s++) setNode(s, 6'(20 + s), 1'b0, 6'd40, 1'b1);
    inValid = 1; step(); clearInputs();
    check("R2 alloc wrapped", 64'(allocBank), 64'd1);
    resValid = 1; resTag = 6'd40; step(); clearInputs();
    check("R5 bank3 older than bank0", 64'(aluDst), 64'({6'd6, 6'd5, 6'd4}));
    step();
    check("R5 bank0 follows", 64'(aluDst), 64'({6'd22, 6'd21, 6'd20}));

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule